// File: doc/BRIEF.md
# Serial Encoder Link Quality Monitor

This block watches the health of a serial position-encoder link one frame at a time. For every frame, the decoder upstream reports whether the fast-position word and the safe-channel word arrived intact or damaged. From these reports the block keeps a 4-bit quality score. The score starts at a middle value, rises on clean frames and falls on damaged ones. The block raises a low-quality warning whenever the score sits below a fixed level.

The block also counts how many fast-position words in a row arrived damaged. Software programs a threshold for this count, and the link is dropped once the count exceeds it. The link is also dropped when the quality score falls to zero. In both cases the block emits a one-cycle reset request to the restart sequencer.

Software can hold the link in reset with a level control. Once that control is released, the block waits for the sequencer to report that the connection is established again. Frame decoding, the physical layer and the restart sequence itself live outside this block.

Top module: `link_qual_mon`

## Requirements
- R1: After synchronous reset, the outputs are as follows: `quality` = 8, `link_up` = 0, `err_count` = 0, `reset_req` = 0 and `low_q_warn` = 1. The threshold register holds its reset value, which is 4 by default.
- R2: `link_estab` is accepted while the link is down and `sw_prst` is 0. On the next cycle, `link_up` = 1, `quality` = 8 and `err_count` = 0. While the link is already up, `link_estab` has no effect.
- R3: While the link is up, each channel contributes to the score once per cycle. A channel adds +1 for a good indication and -1 for a bad one. When a channel reports both at once, the bad indication wins. The sum of the two channels is added to `quality`, which saturates at 0 and at 15.
- R4: `low_q_warn` is 1 exactly when `quality` is below 14.
- R5: While the link is up, `fpos_err` increments `err_count`, which saturates at 255. `fpos_ok` without `fpos_err` clears the count to 0. With neither indication, the count holds.
- R6: A cycle with `thr_we` = 1 loads `thr_wdata` into the threshold. Suppose an update makes `err_count` greater than the threshold while the link is up. On the next cycle, `link_up` = 0 and `reset_req` = 1.
- R7: Suppose an update takes `quality` to 0 while the link is up. On the next cycle, `link_up` = 0 and `reset_req` = 1.
- R8: While `sw_prst` = 1, the following hold one cycle later: `link_up` = 0, `quality` = 8 and `err_count` = 0. `link_estab` is ignored during this time. After `sw_prst` returns to 0, the link stays down until `link_estab` arrives.
- R9: While the link is down, the frame indications have no effect on `quality` or `err_count`.
- R10: `reset_req` lasts exactly one cycle. It never follows a drop caused by `sw_prst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fpos_ok | input | 1 | Fast-position word of this frame arrived intact |
| fpos_err | input | 1 | Fast-position word of this frame arrived damaged |
| safe_ok | input | 1 | Safe-channel word of this frame arrived intact |
| safe_err | input | 1 | Safe-channel word of this frame arrived damaged |
| sw_prst | input | 1 | Software protocol-reset level; 1 holds the link in reset |
| link_estab | input | 1 | Pulse from the restart sequencer: connection established |
| thr_we | input | 1 | Write strobe for the error threshold |
| thr_wdata | input | 8 | Threshold value to write |
| quality | output | 4 | Current quality score |
| link_up | output | 1 | Connection established and healthy |
| low_q_warn | output | 1 | Quality score below 14 |
| err_count | output | 8 | Consecutive damaged fast-position words |
| reset_req | output | 1 | One-cycle protocol reset request |

## Verification
The assertions check five behaviours on every cycle:
- the single-cycle shape of `reset_req` and its tie to a falling `link_up`;
- the bounded per-cycle step of the score;
- the saturating increment of the error count;
- the frozen state while the link is down;
- the initial values forced by `sw_prst` and by `link_estab`.

Two behaviours need the bench's scenarios instead. The first is the exact trip point against a programmed threshold, including the values 0 and 255. The second is the priority of a bad indication over a good one within a channel. These, and the full score trajectory through saturation and the warning boundary at 13 and 14, are compared against a cycle-accurate reference model under seeded random traffic.

// File: rtl/lqm_pkg.sv
package lqm_pkg;

    typedef enum logic [1:0] {
        LNK_DOWN = 2'd0,
        LNK_UP   = 2'd1,
        LNK_HELD = 2'd2
    } link_st_e;

    typedef struct packed {
        logic good;
        logic bad;
    } chan_ind_t;

    // Score contribution of one channel; a damaged word outranks a clean one.
    function automatic int chan_delta(chan_ind_t c);
        if (c.bad)
            return -1;
        else if (c.good)
            return 1;
        else
            return 0;
    endfunction

    function automatic int clamp_int(int v, int lo, int hi);
        if (v < lo)
            return lo;
        else if (v > hi)
            return hi;
        else
            return v;
    endfunction

endpackage

// File: rtl/lqm_score.sv
module lqm_score
    import lqm_pkg::*;
#(
    parameter int QW     = 4,
    parameter int Q_INIT = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_init,
    input  logic          update_en,
    input  chan_ind_t     fp_ind,
    input  chan_ind_t     sf_ind,
    output logic [QW-1:0] q,
    output logic [QW-1:0] q_next
);
    localparam int QMAX = (1 << QW) - 1;

    always_comb begin
        int sum;
        sum = int'(q) + chan_delta(fp_ind) + chan_delta(sf_ind);
        q_next = QW'(clamp_int(sum, 0, QMAX));
    end

    always_ff @(posedge clk) begin
        if (rst || load_init)
            q <= QW'(Q_INIT);
        else if (update_en)
            q <= q_next;
    end
endmodule

// File: rtl/lqm_errcnt.sv
module lqm_errcnt
    import lqm_pkg::*;
#(
    parameter int CW      = 8,
    parameter int THR_RST = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          update_en,
    input  chan_ind_t     fp_ind,
    input  logic          thr_we,
    input  logic [CW-1:0] thr_wdata,
    output logic [CW-1:0] cnt,
    output logic          over_next
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] thr;
    logic [CW-1:0] cnt_next;

    always_comb begin
        if (fp_ind.bad)
            cnt_next = (cnt == CMAX) ? CMAX : cnt + 1'b1;
        else if (fp_ind.good)
            cnt_next = '0;
        else
            cnt_next = cnt;
        over_next = cnt_next > thr;
    end

    always_ff @(posedge clk) begin
        if (rst)
            thr <= CW'(THR_RST);
        else if (thr_we)
            thr <= thr_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (update_en)
            cnt <= cnt_next;
    end
endmodule

// File: rtl/lqm_link.sv
module lqm_link
    import lqm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sw_prst,
    input  logic     link_estab,
    input  logic     trip,
    output link_st_e state,
    output logic     update_en,
    output logic     load_init,
    output logic     reset_req
);
    assign update_en = (state == LNK_UP) && !sw_prst;
    assign load_init = sw_prst || ((state != LNK_UP) && link_estab);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= LNK_DOWN;
            reset_req <= 1'b0;
        end else if (sw_prst) begin
            state     <= LNK_HELD;
            reset_req <= 1'b0;
        end else begin
            reset_req <= 1'b0;
            case (state)
                LNK_UP: begin
                    if (trip) begin
                        state     <= LNK_DOWN;
                        reset_req <= 1'b1;
                    end
                end
                default: begin
                    if (link_estab)
                        state <= LNK_UP;
                    else
                        state <= LNK_DOWN;
                end
            endcase
        end
    end
endmodule

// File: rtl/link_qual_mon.sv
module link_qual_mon
    import lqm_pkg::*;
#(
    parameter int QW      = 4,
    parameter int Q_INIT  = 8,
    parameter int Q_WARN  = 14,
    parameter int CW      = 8,
    parameter int THR_RST = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fpos_ok,
    input  logic          fpos_err,
    input  logic          safe_ok,
    input  logic          safe_err,
    input  logic          sw_prst,
    input  logic          link_estab,
    input  logic          thr_we,
    input  logic [CW-1:0] thr_wdata,
    output logic [QW-1:0] quality,
    output logic          link_up,
    output logic          low_q_warn,
    output logic [CW-1:0] err_count,
    output logic          reset_req
);
    chan_ind_t     fp_ind;
    chan_ind_t     sf_ind;
    link_st_e      state;
    logic          update_en;
    logic          load_init;
    logic          over_next;
    logic [QW-1:0] q_next;
    logic          trip;

    assign fp_ind = '{good: fpos_ok, bad: fpos_err};
    assign sf_ind = '{good: safe_ok, bad: safe_err};

    lqm_score #(.QW(QW), .Q_INIT(Q_INIT)) u_score (
        .clk       (clk),
        .rst       (rst),
        .load_init (load_init),
        .update_en (update_en),
        .fp_ind    (fp_ind),
        .sf_ind    (sf_ind),
        .q         (quality),
        .q_next    (q_next)
    );

    lqm_errcnt #(.CW(CW), .THR_RST(THR_RST)) u_errcnt (
        .clk       (clk),
        .rst       (rst),
        .clear     (load_init),
        .update_en (update_en),
        .fp_ind    (fp_ind),
        .thr_we    (thr_we),
        .thr_wdata (thr_wdata),
        .cnt       (err_count),
        .over_next (over_next)
    );

    assign trip = update_en && ((q_next == '0) || over_next);

    lqm_link u_link (
        .clk        (clk),
        .rst        (rst),
        .sw_prst    (sw_prst),
        .link_estab (link_estab),
        .trip       (trip),
        .state      (state),
        .update_en  (update_en),
        .load_init  (load_init),
        .reset_req  (reset_req)
    );

    assign link_up    = (state == LNK_UP);
    assign low_q_warn = (int'(quality) < Q_WARN);
endmodule

// File: rtl/link_qual_mon_chk.sv
module link_qual_mon_chk #(
    parameter int QW = 4,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          fpos_err,
    input logic          sw_prst,
    input logic          link_estab,
    input logic [QW-1:0] quality,
    input logic          link_up,
    input logic [CW-1:0] err_count,
    input logic          reset_req
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    // R10: the request never lasts two cycles
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    // R7 / R6: a request accompanies a link that has just dropped
    p_req_on_drop_r7: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> (!link_up && $past(link_up)));

    // R3: the score moves by at most two per cycle while up
    p_score_step_r3: assert property (@(posedge clk) disable iff (rst)
        (link_up && !sw_prst) |=>
            ((int'(quality) - int'($past(quality)) <= 2) &&
             (int'($past(quality)) - int'(quality) <= 2)));

    // R5: a damaged fast-position word bumps the count, saturating
    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        (link_up && !sw_prst && fpos_err) |=>
            (err_count == (($past(err_count) == CMAX) ? CMAX : $past(err_count) + 1'b1)));

    // R8: software reset forces the initial state
    p_sw_hold_r8: assert property (@(posedge clk) disable iff (rst)
        sw_prst |=> (!link_up && quality == QW'(8) && err_count == '0 && !reset_req));

    // R9: nothing moves while the link is down
    p_down_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (!link_up && !link_estab && !sw_prst) |=> ($stable(quality) && $stable(err_count)));

    // R2: establishment brings the link up with fresh values
    p_establish_r2: assert property (@(posedge clk) disable iff (rst)
        (!link_up && link_estab && !sw_prst) |=>
            (link_up && quality == QW'(8) && err_count == '0));
endmodule

bind link_qual_mon link_qual_mon_chk #(.QW(QW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fpos_err   (fpos_err),
    .sw_prst    (sw_prst),
    .link_estab (link_estab),
    .quality    (quality),
    .link_up    (link_up),
    .err_count  (err_count),
    .reset_req  (reset_req)
);

// File: tb/link_qual_mon_test.sv
module link_qual_mon_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic       fpos_ok, fpos_err, safe_ok, safe_err;
    logic       sw_prst, link_estab, thr_we;
    logic [7:0] thr_wdata;
    logic [3:0] quality;
    logic       link_up, low_q_warn, reset_req;
    logic [7:0] err_count;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    // reference model state
    int m_q, m_cnt, m_thr;
    bit m_link, m_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_qual_mon uut (
        .clk(clk), .rst(rst),
        .fpos_ok(fpos_ok), .fpos_err(fpos_err),
        .safe_ok(safe_ok), .safe_err(safe_err),
        .sw_prst(sw_prst), .link_estab(link_estab),
        .thr_we(thr_we), .thr_wdata(thr_wdata),
        .quality(quality), .link_up(link_up), .low_q_warn(low_q_warn),
        .err_count(err_count), .reset_req(reset_req)
    );

    function automatic int ch_step(bit ok, bit bad);
        return bad ? -1 : (ok ? 1 : 0);
    endfunction

    function automatic int sat(int v, int hi);
        return (v < 0) ? 0 : ((v > hi) ? hi : v);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic check_all();
        chk("R3 quality", int'(quality), m_q);
        chk("R2 link_up", int'(link_up), int'(m_link));
        chk("R4 low_q_warn", int'(low_q_warn), int'(m_q < 14));
        chk("R5 err_count", int'(err_count), m_cnt);
        chk("R10 reset_req", int'(reset_req), int'(m_req));
    endtask

    task automatic model_step(bit fo, bit fe, bit so, bit se, bit sp, bit es, bit we, int wd);
        int nq, nc;
        m_req = 0;
        if (sp) begin
            m_link = 0; m_q = 8; m_cnt = 0;
        end else if (m_link) begin
            nq = sat(m_q + ch_step(fo, fe) + ch_step(so, se), 15);
            nc = fe ? sat(m_cnt + 1, 255) : (fo ? 0 : m_cnt);
            if (nq == 0 || nc > m_thr) begin
                m_link = 0; m_req = 1;
            end
            m_q = nq; m_cnt = nc;
        end else if (es) begin
            m_link = 1; m_q = 8; m_cnt = 0;
        end
        if (we) m_thr = wd;
    endtask

    task automatic step(bit fo, bit fe, bit so, bit se, bit sp, bit es, bit we, int wd);
        @(negedge clk);
        fpos_ok = fo; fpos_err = fe; safe_ok = so; safe_err = se;
        sw_prst = sp; link_estab = es; thr_we = we; thr_wdata = 8'(wd);
        @(posedge clk);
        #1;
        model_step(fo, fe, so, se, sp, es, we, wd);
        check_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED1234;
        void'($urandom(seed));
        rst = 1; fpos_ok = 0; fpos_err = 0; safe_ok = 0; safe_err = 0;
        sw_prst = 0; link_estab = 0; thr_we = 0; thr_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_q = 8; m_cnt = 0; m_thr = 4; m_link = 0; m_req = 0;
        // R1: reset state
        #1;
        chk("R1 quality", int'(quality), 8);
        chk("R1 link_up", int'(link_up), 0);
        chk("R1 err_count", int'(err_count), 0);
        chk("R1 low_q_warn", int'(low_q_warn), 1);
        chk("R1 reset_req", int'(reset_req), 0);

        // R9: indications ignored while down
        step(0, 1, 0, 1, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0, 0, 0);
        // R2: establish
        step(0, 0, 0, 0, 0, 1, 0, 0);
        // R3: climb and saturate at 15; R4 warning clears at 14
        for (int i = 0; i < 5; i++) step(1, 0, 1, 0, 0, 0, 0, 0);
        chk("R3 saturate", int'(quality), 15);
        // R3: bad beats good in one channel
        step(1, 1, 1, 0, 0, 0, 0, 0);
        chk("R3 priority", int'(quality), 15);
        chk("R5 count after err", int'(err_count), 1);
        step(0, 0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R4 warn at 13", int'(low_q_warn), 1);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        chk("R4 no warn at 14", int'(low_q_warn), 0);
        // R6: threshold 2, third consecutive error trips
        step(0, 0, 0, 0, 0, 0, 1, 2);
        step(0, 1, 1, 0, 0, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0, 0, 0);
        chk("R6 not yet", int'(link_up), 1);
        step(0, 1, 1, 0, 0, 0, 0, 0);
        chk("R6 trip req", int'(reset_req), 1);
        chk("R6 trip link", int'(link_up), 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R10 pulse ends", int'(reset_req), 0);
        // R7: quality to zero
        step(0, 0, 0, 0, 0, 0, 1, 255);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 0, 0, 0, 0);
        chk("R7 zero req", int'(reset_req), 1);
        chk("R7 zero quality", int'(quality), 0);
        // R8: software reset held, estab ignored, stays down after release
        step(0, 0, 0, 0, 1, 1, 0, 0);
        step(1, 0, 1, 0, 1, 1, 0, 0);
        chk("R8 held", int'(link_up), 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R8 after release", int'(link_up), 0);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        // R6: threshold 0, first error trips
        step(0, 0, 0, 0, 0, 0, 1, 0);
        step(0, 1, 0, 0, 0, 0, 0, 0);
        chk("R6 thr0 trip", int'(reset_req), 1);
        idle(2);

        // random phase
        step(0, 0, 0, 0, 0, 0, 1, 6);
        for (int i = 0; i < 4000; i++) begin
            int r;
            bit fo, fe, so, se, sp, es, we;
            r  = $urandom_range(0, 99);
            fe = (r < 20);
            fo = (r >= 12) && (r < 85);
            r  = $urandom_range(0, 99);
            se = (r < 22);
            so = (r >= 15) && (r < 88);
            sp = ($urandom_range(0, 199) == 0);
            es = ($urandom_range(0, 7) == 0);
            we = ($urandom_range(0, 99) == 0);
            step(fo, fe, so, se, sp, es, we, $urandom_range(0, 12));
        end
        finish_run();
    end
endmodule